// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a 32.768 kHz oscillator enable into a single-cycle strobe once per second, and corrects the rate by a small signed amount in parts per million. A whole second can only be lengthened or shortened by one oscillator count, and one count is about 30.5 ppm. A finer correction is therefore made on average: a fractional accumulator collects the requested error at each second boundary. Whenever the accumulator has gathered a full count, the following second is one count shorter or one count longer.

The correction is chosen by a 3-bit code. One bit gives the direction and two weighted bits give the size, which can be 0, 10, 20 or 30 ppm. The block samples the code only at second boundaries, so software may rewrite it at any time without producing a malformed second. A second output goes high together with the strobe that ends a corrected second, so the correction rate can be observed at the pins.

Top module: `sec_prescaler_trim`

## Requirements
- R1: While `rst_n` is low, `sec_tick` and `sec_corrected` are low at the next clock edge. After reset, the first strobe follows exactly NOMINAL_TICKS oscillator enables (default 32768), whatever the trim code is.
- R2: With a trim magnitude of zero, every second lasts exactly NOMINAL_TICKS enables and `sec_corrected` stays low.
- R3: `sec_tick` is high for exactly one clock cycle. That cycle follows the clock edge that sampled the final enable of the second.
- R4: Only cycles with `osc_en` high advance the divider. Gaps between enables stretch the second in clock cycles but do not change its length in enables.
- R5: Trim code layout: bit 2 is the direction (1 = positive, 0 = negative), bit 0 is worth PPM_STEP (10 ppm) and bit 1 is worth 2×PPM_STEP (20 ppm). At each boundary the accumulator gains NOMINAL_TICKS × magnitude.
- R6: When the sum reaches PPM_DENOM (1,000,000) or more, PPM_DENOM is subtracted. If the direction bit is 1, the next second is one enable shorter.
- R7: If the direction bit is 0 under the same condition, the next second is one enable longer.
- R8: `sec_corrected` is high only in the same cycle as `sec_tick`, and only when the second just ended had a corrected length.
- R9: The trim code is sampled only at the enable that ends a second. Changes that are undone before that enable have no effect.
- R10: When the sampled direction bit differs from the one sampled at the previous boundary, the accumulator is cleared before the new magnitude is added.
- R11: A code with the direction bit set and a zero magnitude (3'b100) gives no correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| trim_code | input | 3 | Direction bit 2, 20 ppm bit 1, 10 ppm bit 0 |
| sec_tick | output | 1 | One-cycle strobe per second |
| sec_corrected | output | 1 | High with the strobe ending a corrected second |

## Verification
At a single boundary enable, the divider must restart its count while the accumulator overflows and decides the length of the coming second. If the trim code also changes direction, the accumulator must additionally clear within that same cycle. The bench first builds up the accumulator with a positive code, then switches to a negative code just before an overflow boundary. A per-second reference model then checks the length of every following second and its correction flag, and the totals are compared with counts worked out by hand. Because the design runs with a small nominal second and a small denominator, many overflows occur in a short run, so a wrong ordering of clear, add and subtract shows up as a second of the wrong length.

// File: rtl/sptrim_pkg.sv
// Shared types for the trimmed seconds prescaler.
// Assumes nothing beyond the trim code layout stated in the brief.
package sptrim_pkg;

    // Length choice for the second currently being counted
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

    // Trim code: direction in the top bit, weighted magnitude below
    typedef struct packed {
        logic       positive;
        logic [1:0] mag;
    } trim_t;

endpackage

// File: rtl/sptrim_decode.sv
// Trim decoder: turns the 3-bit code into a direction and the per-second
// accumulator increment NOMINAL_TICKS * magnitude_ppm.
// Assumes the increment for the largest magnitude fits in ACC_W bits.
module sptrim_decode
    import sptrim_pkg::*;
#(
    parameter int NOMINAL_TICKS = 32768,
    parameter int PPM_STEP      = 10,
    parameter int ACC_W         = 21
) (
    input  trim_t            code,
    output logic             positive,
    output logic [ACC_W-1:0] step_inc
);

    localparam logic [ACC_W-1:0] INC_LO = ACC_W'(NOMINAL_TICKS * PPM_STEP);
    localparam logic [ACC_W-1:0] INC_HI = ACC_W'(NOMINAL_TICKS * PPM_STEP * 2);

    // Sum the weighted magnitude bits into one increment
    always_comb begin
        step_inc = '0;
        if (code.mag[0]) step_inc = step_inc + INC_LO;
        if (code.mag[1]) step_inc = step_inc + INC_HI;
    end

    assign positive = code.positive;

endmodule

// File: rtl/sptrim_accum.sv
// Fractional correction accumulator. At each second boundary it adds the
// increment (after clearing on a direction change), wraps at PPM_DENOM and
// registers the length choice for the next second.
// Assumes step_inc < PPM_DENOM so that a single subtraction suffices.
module sptrim_accum
    import sptrim_pkg::*;
#(
    parameter int PPM_DENOM = 1000000,
    parameter int ACC_W     = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             positive,
    input  logic [ACC_W-1:0] step_inc,
    output adj_e             adj
);

    localparam logic [ACC_W-1:0] DENOM_V = ACC_W'(PPM_DENOM);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_d;
    logic             dir_q;
    logic             wrap;
    adj_e             adj_q;

    // Clear on a direction change, add, then wrap once at the denominator
    always_comb begin
        acc_base = (positive != dir_q) ? '0 : acc_q;
        acc_sum  = acc_base + step_inc;
        wrap     = (acc_sum >= DENOM_V);
        acc_d    = wrap ? (acc_sum - DENOM_V) : acc_sum;
    end

    // Update the accumulator and next-second length at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            dir_q <= 1'b0;
            adj_q <= ADJ_NONE;
        end else if (boundary) begin
            acc_q <= acc_d;
            dir_q <= positive;
            if (!wrap)         adj_q <= ADJ_NONE;
            else if (positive) adj_q <= ADJ_SHORT;
            else               adj_q <= ADJ_LONG;
        end
    end

    assign adj = adj_q;

endmodule

// File: rtl/sptrim_divider.sv
// Seconds divider: counts oscillator enables up to a length that is the
// nominal value, or one less or one more as chosen by adj. It flags the
// boundary enable and registers the strobe and the corrected flag.
// Assumes NOMINAL_TICKS >= 3.
module sptrim_divider
    import sptrim_pkg::*;
#(
    parameter int NOMINAL_TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  adj_e adj,
    output logic boundary,
    output logic sec_tick,
    output logic sec_corrected
);

    localparam int CNT_W = $clog2(NOMINAL_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_NOM   = CNT_W'(NOMINAL_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(NOMINAL_TICKS - 2);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(NOMINAL_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic             tick_q;
    logic             corr_q;

    // Select the final count index for the current second
    always_comb begin
        case (adj)
            ADJ_SHORT: last_idx = LAST_SHORT;
            ADJ_LONG:  last_idx = LAST_LONG;
            default:   last_idx = LAST_NOM;
        endcase
    end

    assign boundary = osc_en && (cnt_q == last_idx);

    // Advance the count on enables, register strobe and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
            corr_q <= 1'b0;
        end else begin
            tick_q <= boundary;
            corr_q <= boundary && (adj != ADJ_NONE);
            if (osc_en) cnt_q <= boundary ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_tick      = tick_q;
    assign sec_corrected = corr_q;

endmodule

// File: rtl/sec_prescaler_trim.sv
// Top of the trimmed seconds prescaler: decoder, accumulator, divider.
// Assumes osc_en is a one-cycle enable synchronous to clk and that
// NOMINAL_TICKS * 3 * PPM_STEP < PPM_DENOM.
module sec_prescaler_trim
    import sptrim_pkg::*;
#(
    parameter int NOMINAL_TICKS = 32768,
    parameter int PPM_DENOM     = 1000000,
    parameter int PPM_STEP      = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [2:0] trim_code,
    output logic       sec_tick,
    output logic       sec_corrected
);

    localparam int ACC_W = $clog2(2 * PPM_DENOM);

    trim_t            code;
    logic             positive;
    logic [ACC_W-1:0] step_inc;
    logic             boundary;
    adj_e             adj;

    assign code = trim_t'(trim_code);

    sptrim_decode #(
        .NOMINAL_TICKS(NOMINAL_TICKS),
        .PPM_STEP     (PPM_STEP),
        .ACC_W        (ACC_W)
    ) u_decode (
        .code    (code),
        .positive(positive),
        .step_inc(step_inc)
    );

    sptrim_accum #(
        .PPM_DENOM(PPM_DENOM),
        .ACC_W    (ACC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .boundary(boundary),
        .positive(positive),
        .step_inc(step_inc),
        .adj     (adj)
    );

    sptrim_divider #(
        .NOMINAL_TICKS(NOMINAL_TICKS)
    ) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en       (osc_en),
        .adj          (adj),
        .boundary     (boundary),
        .sec_tick     (sec_tick),
        .sec_corrected(sec_corrected)
    );

endmodule

// File: rtl/sptrim_chk.sv
// Checker for the trimmed seconds prescaler, bound to the top module.
// Counts enables between strobes itself, so long windows need no $past.
module sptrim_chk #(
    parameter int NOMINAL_TICKS = 32768
) (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic sec_tick,
    input logic sec_corrected
);

    logic [31:0] ticks_seen;

    // Enables sampled since the previous strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ticks_seen <= '0;
        else        ticks_seen <= (sec_tick ? 32'd0 : ticks_seen) + {31'd0, osc_en};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sec_tick && !sec_corrected));

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R4
    tick_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_en));

    // R8
    corr_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_corrected |-> sec_tick);

    // R6
    len_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (ticks_seen >= 32'(NOMINAL_TICKS - 1) && ticks_seen <= 32'(NOMINAL_TICKS + 1)));

    // R2
    len_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !sec_corrected) |-> (ticks_seen == 32'(NOMINAL_TICKS)));

endmodule

bind sec_prescaler_trim sptrim_chk #(.NOMINAL_TICKS(NOMINAL_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_en       (osc_en),
    .sec_tick     (sec_tick),
    .sec_corrected(sec_corrected)
);

// File: tb/tb_sec_prescaler_trim.sv
// Directed bench for the trimmed seconds prescaler. A monitor runs a
// per-second reference model built from the requirements; each task also
// checks totals worked out by hand.
module tb_sec_prescaler_trim;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int DEN        = 1000;
    localparam int STEP       = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic [2:0] trim_code = 3'b000;
    logic       sec_tick;
    logic       sec_corrected;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // monitor and model state
    int tick_cnt = 0;
    int sec_count = 0;
    int corr_count = 0;
    int tick_total = 0;
    int cyc = 0;
    int last_sec_cyc = 0;
    int prev_sec_cyc = 0;
    int m_len = N;
    bit m_adj = 0;
    int m_acc = 0;
    bit m_sign = 0;
    bit prev_tick = 0;

    sec_prescaler_trim #(
        .NOMINAL_TICKS(N),
        .PPM_DENOM    (DEN),
        .PPM_STEP     (STEP)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en       (osc_en),
        .trim_code    (trim_code),
        .sec_tick     (sec_tick),
        .sec_corrected(sec_corrected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: samples 2 time units after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (!rst_n) begin
            tick_cnt = 0; m_len = N; m_adj = 0; m_acc = 0; m_sign = 0; prev_tick = 0;
        end else begin
            if (osc_en) tick_cnt++;
            check(!(sec_tick && prev_tick), "R3", 1, 0);
            if (sec_tick) begin
                int mag;
                check(tick_cnt == m_len, cur_req, tick_cnt, m_len);
                check(sec_corrected == m_adj, "R8", int'(sec_corrected), int'(m_adj));
                sec_count++;
                tick_total += tick_cnt;
                if (sec_corrected) corr_count++;
                prev_sec_cyc = last_sec_cyc;
                last_sec_cyc = cyc;
                tick_cnt = 0;
                // model update from the trim code at this boundary (R5, R10)
                mag = (trim_code[0] ? STEP : 0) + (trim_code[1] ? 2*STEP : 0);
                if (trim_code[2] != m_sign) m_acc = 0;
                m_sign = trim_code[2];
                m_acc += N * mag;
                if (m_acc >= DEN) begin
                    m_acc -= DEN;
                    m_adj = 1;
                    m_len = trim_code[2] ? N - 1 : N + 1;
                end else begin
                    m_adj = 0;
                    m_len = N;
                end
            end else begin
                check(!sec_corrected, "R8", int'(sec_corrected), 0);
            end
            prev_tick = sec_tick;
        end
    end

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        osc_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(!sec_tick && !sec_corrected, "R1", int'(sec_tick), 0);
        trim_code = code;
        rst_n = 1'b1;
        sec_count = 0; corr_count = 0; tick_total = 0;
    endtask

    task automatic run_seconds(input int n, input int gap);
        int target = sec_count + n;
        int phase = 0;
        forever begin
            @(negedge clk);
            if (sec_count >= target) begin
                osc_en = 1'b0;
                break;
            end
            osc_en = (phase == 0);
            phase = (phase + 1) % gap;
        end
    endtask

    task automatic t_nominal();
        cur_req = "R2";
        do_reset(3'b000);
        run_seconds(5, 1);
        check(tick_total == 5*N, "R1", tick_total, 5*N);
        check(corr_count == 0, "R2", corr_count, 0);
    endtask

    task automatic t_pos10();
        cur_req = "R6";
        do_reset(3'b101);
        run_seconds(20, 1);
        // R5 R6: overflows at boundaries 7, 13, 19
        check(corr_count == 3, "R6", corr_count, 3);
        check(tick_total == 20*N - 3, "R5", tick_total, 20*N - 3);
    endtask

    task automatic t_pos20();
        cur_req = "R5";
        do_reset(3'b110);
        run_seconds(12, 1);
        check(corr_count == 3, "R5", corr_count, 3);
        check(tick_total == 12*N - 3, "R6", tick_total, 12*N - 3);
    endtask

    task automatic t_neg30();
        cur_req = "R7";
        do_reset(3'b011);
        run_seconds(12, 1);
        check(corr_count == 5, "R7", corr_count, 5);
        check(tick_total == 12*N + 5, "R7", tick_total, 12*N + 5);
    endtask

    task automatic t_signed_zero();
        cur_req = "R11";
        do_reset(3'b100);
        run_seconds(10, 1);
        check(corr_count == 0, "R11", corr_count, 0);
        check(tick_total == 10*N, "R11", tick_total, 10*N);
    endtask

    task automatic t_sign_clear();
        cur_req = "R10";
        do_reset(3'b111);
        run_seconds(2, 1);
        trim_code = 3'b011;
        corr_count = 0; tick_total = 0;
        run_seconds(4, 1);
        // R10: cleared at boundary 3, overflow only at boundary 5
        check(corr_count == 1, "R10", corr_count, 1);
        check(tick_total == 4*N + 1, "R10", tick_total, 4*N + 1);
    endtask

    task automatic t_mid_change();
        cur_req = "R9";
        do_reset(3'b000);
        for (int s = 0; s < 10; s++) begin
            int target = sec_count + 1;
            int k = 0;
            forever begin
                @(negedge clk);
                if (sec_count >= target) begin
                    osc_en = 1'b0;
                    break;
                end
                if (k == 4) trim_code = 3'b111;
                if (k == 12) trim_code = 3'b000;
                osc_en = 1'b1;
                k++;
            end
        end
        check(corr_count == 0, "R9", corr_count, 0);
        check(tick_total == 10*N, "R9", tick_total, 10*N);
    endtask

    task automatic t_sparse();
        cur_req = "R4";
        do_reset(3'b101);
        run_seconds(9, 3);
        // R4: ninth second is a nominal one spanning 3*N clock cycles
        check(last_sec_cyc - prev_sec_cyc == 3*N, "R4", last_sec_cyc - prev_sec_cyc, 3*N);
        check(tick_total == 9*N - 1, "R4", tick_total, 9*N - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_nominal();
        t_pos10();
        t_pos20();
        t_neg30();
        t_signed_zero();
        t_sign_clear();
        t_mid_change();
        t_sparse();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule